// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs one memory or I/O transfer at a time on a bus where the same sixteen lines carry first the address and then the data. A request gives the direction, memory or I/O space, a 20-bit byte address, a byte or word size, a two-bit segment code and the write data. The block steps through the bus states. It pulses an address latch strobe so that an external latch can hold the address, then hands the lines over to the data phase. It drives the read or write strobe, the data buffer direction and enable, the byte-high enable and the status code on the four upper address lines. During the data phase it extends the cycle with wait states for as long as the READY input is low.

The states are ST_IDLE, ST_T1, ST_T2, ST_T3, ST_TW and ST_T4. The transitions are:

- ST_IDLE to ST_T1 when a request is accepted.
- ST_T1 to ST_T2, and ST_T2 to ST_T3, unconditionally.
- ST_T3 to ST_T4 if READY is high, or ST_T3 to ST_TW if it is low.
- ST_TW to ST_TW while READY stays low, and ST_TW to ST_T4 once it is high.
- ST_T4 to ST_T1 when the second half of a split access is still to run, and ST_T4 to ST_IDLE otherwise.

A word request at an odd address is carried out as two byte cycles. The first goes to the odd address on the high lane. The second goes to the following even address on the low lane.

The shared lines are split into an output value, an output enable and a separate input, so that a pad ring can form the tri-state pins.

Top module: `mux_bus_sequencer`

## Requirements
- R1: While `busy` is low, `ad_oe`, `ast_oe`, `ale` and `den` are 0, `rd_n`, `wr_n` and `bhe_n` are 1, and `done` is 0. This holds from reset.
- R2: A request seen with `req_valid` high while idle moves the block to ST_T1 on the next clock. In ST_T1, `ale` is 1 for exactly that one cycle, `ad_out` carries address bits 15:0 with `ad_oe`=1, and `ast_out` carries address bits 19:16 with `ast_oe`=1. Request inputs are ignored after acceptance.
- R3: In a read, `ad_oe` is 0 from ST_T2 through ST_T4. `rd_n` and `den` are 0 and 1 in ST_T2, ST_T3 and ST_TW, and `dtr` is 0 throughout the cycle. In ST_T4, `rd_n` is 1 and `den` is 0.
- R4: In a write, `ad_oe` stays 1 from ST_T2 through ST_T4 with the lane data on `ad_out`. `wr_n` is 0 and `den` is 1 in ST_T2, ST_T3 and ST_TW, and `dtr` is 1 throughout the cycle.
- R5: READY is sampled on the clock edge that ends ST_T3 and each ST_TW. Each low sample adds one more ST_TW cycle, so N low samples give N wait states.
- R6: From ST_T2 through ST_T4, `ast_out` equals {2'b00, segment}. The segment codes are 00 extra, 01 stack, 10 code/none and 11 data.
- R7: The byte select on the pair (`bhe_n`, address bit 0) is held from ST_T1 through ST_T4. An aligned word gives (0,0). A byte at an odd address gives (0,1). A byte at an even address gives (1,0).
- R8: A byte write puts the byte on both lanes. A byte read returns the high lane (odd address) or the low lane (even address) in `rdata[7:0]`, with `rdata[15:8]`=0. An aligned word read returns all 16 lines.
- R9: A word at odd address A runs two cycles. The first is at A with `bhe_n`=0 and carries data bits 7:0. The second is at (A+1) mod 2^20 with `bhe_n`=1 and carries data bits 15:8. The read result is {second low lane, first high lane}.
- R10: `done` is a one-cycle pulse in ST_T4 of the final cycle only. `rdata` is valid from that cycle, and the block is idle on the next clock.
- R11: `mio` is 1 for memory and 0 for I/O from ST_T1 through ST_T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, accepted while idle |
| req_write | input | 1 | 1 write, 0 read |
| req_io | input | 1 | 1 I/O space, 0 memory |
| req_word | input | 1 | 1 word, 0 byte |
| req_addr | input | 20 | Byte address |
| req_seg | input | 2 | Segment code for status |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| ready | input | 1 | Wait-state control, low extends the cycle |
| ad_in | input | 16 | Value seen on the shared lines |
| ad_out | output | 16 | Value driven on the shared lines |
| ad_oe | output | 1 | Output enable of the shared lines |
| ast_out | output | 4 | Upper address, then status |
| ast_oe | output | 1 | Output enable of the upper lines |
| ale | output | 1 | Address latch strobe |
| bhe_n | output | 1 | Byte-high enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| mio | output | 1 | 1 memory, 0 I/O |
| dtr | output | 1 | Buffer direction, 1 transmit |
| den | output | 1 | Data buffer enable |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | Final cycle completes |
| rdata | output | 16 | Assembled read data |

## Verification
A state register that skips or repeats a state shows up in the very next cycle. Symptoms are `ale` lasting two cycles, a strobe falling in ST_T1, or `done` arriving one cycle early or late against the number of READY samples that were low. A wrong part bit in a split access shows up at the next ST_T1, as an address not advanced by one or a wrong `bhe_n`. A lane mix-up in the captured read data is visible at the `done` cycle. Every cycle of every transfer is compared, so each such fault is reported within the transfer that causes it.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_TW,
        ST_T4
    } bus_state_t;

endpackage

// File: rtl/busseq_fsm.sv
module busseq_fsm
    import busseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       ready,
    input  logic       split,
    output bus_state_t state,
    output logic       part,
    output logic       done
);

    bus_state_t nxt;
    logic       last;

    assign last = !split || part;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = start ? ST_T1 : ST_IDLE;
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ST_T3;
            ST_T3:   nxt = ready ? ST_T4 : ST_TW;
            ST_TW:   nxt = ready ? ST_T4 : ST_TW;
            ST_T4:   nxt = last ? ST_IDLE : ST_T1;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            part  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE)
                part <= 1'b0;
            else if (state == ST_T4 && !last)
                part <= 1'b1;
        end
    end

    always_comb begin
        done = (state == ST_T4) && last;
    end

    AST_START_GOES_T1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (state == ST_T1)); // R2
    AST_WAIT_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_T3 || state == ST_TW) && !ready) |=> (state == ST_TW)); // R5
    AST_READY_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_T3 || state == ST_TW) && ready) |=> (state == ST_T4)); // R5
    AST_SECOND_PART_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T4 && part) |=> (state == ST_IDLE)); // R9

endmodule

// File: rtl/busseq_lanes.sv
module busseq_lanes #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              word,
    input  logic              part,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] ad_in,
    input  logic              capture,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic              cyc_bhe_n,
    output logic [DATA_W-1:0] lane_wdata,
    output logic              split,
    output logic [DATA_W-1:0] rdata
);

    localparam int BYTE_W = DATA_W / 2;

    logic              aligned_word;
    logic [BYTE_W-1:0] wbyte;
    logic [BYTE_W-1:0] rbyte;

    always_comb begin
        split        = word && base_addr[0];
        aligned_word = word && !base_addr[0];
        cyc_addr     = part ? (base_addr + ADDR_W'(1)) : base_addr;
        cyc_bhe_n    = aligned_word ? 1'b0 : !cyc_addr[0];
        wbyte        = (split && part) ? wdata[DATA_W-1:BYTE_W] : wdata[BYTE_W-1:0];
        lane_wdata   = aligned_word ? wdata : {wbyte, wbyte};
        rbyte        = cyc_addr[0] ? ad_in[DATA_W-1:BYTE_W] : ad_in[BYTE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            if (aligned_word)
                rdata <= ad_in;
            else if (!split)
                rdata <= {{BYTE_W{1'b0}}, rbyte};
            else if (!part)
                rdata[BYTE_W-1:0] <= rbyte;
            else
                rdata[DATA_W-1:BYTE_W] <= rbyte;
        end
    end

    AST_SPLIT_SECOND_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (split && part) |-> (cyc_bhe_n && !cyc_addr[0])); // R9

endmodule

// File: rtl/mux_bus_sequencer.sv
module mux_bus_sequencer
    import busseq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SEG_W  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_io,
    input  logic                 req_word,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [SEG_W-1:0]     req_seg,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic                 ready,
    input  logic [DATA_W-1:0]    ad_in,
    output logic [DATA_W-1:0]    ad_out,
    output logic                 ad_oe,
    output logic [ADDR_W-DATA_W-1:0] ast_out,
    output logic                 ast_oe,
    output logic                 ale,
    output logic                 bhe_n,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic                 mio,
    output logic                 dtr,
    output logic                 den,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_W-1:0]    rdata
);

    localparam int UPPER_W = ADDR_W - DATA_W;

    bus_state_t          state;
    logic                part;
    logic                split;
    logic                accept;
    logic                capture;
    logic                cur_write;
    logic                cur_io;
    logic                cur_word;
    logic [ADDR_W-1:0]   cur_addr;
    logic [SEG_W-1:0]    cur_seg;
    logic [DATA_W-1:0]   cur_wdata;
    logic [ADDR_W-1:0]   cyc_addr;
    logic                cyc_bhe_n;
    logic [DATA_W-1:0]   lane_wdata;
    logic [UPPER_W-1:0]  status;

    assign accept  = (state == ST_IDLE) && req_valid;
    assign capture = (state == ST_T3 || state == ST_TW) && ready && !cur_write;
    assign status  = UPPER_W'(cur_seg);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_write <= 1'b0;
            cur_io    <= 1'b0;
            cur_word  <= 1'b0;
            cur_addr  <= '0;
            cur_seg   <= '0;
            cur_wdata <= '0;
        end else if (accept) begin
            cur_write <= req_write;
            cur_io    <= req_io;
            cur_word  <= req_word;
            cur_addr  <= req_addr;
            cur_seg   <= req_seg;
            cur_wdata <= req_wdata;
        end
    end

    busseq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .ready (ready),
        .split (split),
        .state (state),
        .part  (part),
        .done  (done)
    );

    busseq_lanes #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_lanes (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_addr  (cur_addr),
        .word       (cur_word),
        .part       (part),
        .wdata      (cur_wdata),
        .ad_in      (ad_in),
        .capture    (capture),
        .cyc_addr   (cyc_addr),
        .cyc_bhe_n  (cyc_bhe_n),
        .lane_wdata (lane_wdata),
        .split      (split),
        .rdata      (rdata)
    );

    always_comb begin
        ad_oe   = 1'b0;
        ad_out  = '0;
        ast_oe  = 1'b0;
        ast_out = '0;
        ale     = 1'b0;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        den     = 1'b0;
        dtr     = 1'b0;
        mio     = 1'b0;
        bhe_n   = 1'b1;
        busy    = (state != ST_IDLE);
        unique case (state)
            ST_IDLE: begin
            end
            ST_T1: begin
                ad_oe   = 1'b1;
                ad_out  = cyc_addr[DATA_W-1:0];
                ast_oe  = 1'b1;
                ast_out = cyc_addr[ADDR_W-1:DATA_W];
                ale     = 1'b1;
                dtr     = cur_write;
                mio     = !cur_io;
                bhe_n   = cyc_bhe_n;
            end
            ST_T2, ST_T3, ST_TW: begin
                ast_oe  = 1'b1;
                ast_out = status;
                dtr     = cur_write;
                mio     = !cur_io;
                bhe_n   = cyc_bhe_n;
                den     = 1'b1;
                if (cur_write) begin
                    ad_oe  = 1'b1;
                    ad_out = lane_wdata;
                    wr_n   = 1'b0;
                end else begin
                    rd_n   = 1'b0;
                end
            end
            ST_T4: begin
                ast_oe  = 1'b1;
                ast_out = status;
                dtr     = cur_write;
                mio     = !cur_io;
                bhe_n   = cyc_bhe_n;
                if (cur_write) begin
                    ad_oe  = 1'b1;
                    ad_out = lane_wdata;
                end
            end
            default: begin
            end
        endcase
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ad_oe && !ast_oe && !ale && !den && rd_n && wr_n && bhe_n && !done)); // R1
    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale); // R2
    AST_ALE_WITH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && ast_oe && rd_n && wr_n && !den)); // R2
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (!ad_oe && !dtr)); // R3
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (ad_oe && dtr && rd_n)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R10
    AST_STROBE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_n && wr_n && !den)); // R10

endmodule

// File: tb/mux_bus_sequencer_bench.sv
module mux_bus_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_io, req_word;
    logic [19:0] req_addr;
    logic [1:0]  req_seg;
    logic [15:0] req_wdata;
    logic        ready;
    logic [15:0] ad_in;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [3:0]  ast_out;
    logic        ast_oe, ale, bhe_n, rd_n, wr_n, mio, dtr, den, busy, done;
    logic [15:0] rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mux_bus_sequencer u_mux_bus_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_io(req_io), .req_word(req_word), .req_addr(req_addr), .req_seg(req_seg),
        .req_wdata(req_wdata), .ready(ready), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .ast_out(ast_out), .ast_oe(ast_oe), .ale(ale), .bhe_n(bhe_n),
        .rd_n(rd_n), .wr_n(wr_n), .mio(mio), .dtr(dtr), .den(den), .busy(busy),
        .done(done), .rdata(rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] pat(input logic [19:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5AC3;
    endfunction

    task automatic check_idle(input string req);
        check({req, " busy"}, busy, 0);
        check({req, " ad_oe"}, ad_oe, 0);
        check({req, " ast_oe"}, ast_oe, 0);
        check({req, " ale"}, ale, 0);
        check({req, " den"}, den, 0);
        check({req, " strobes"}, {rd_n, wr_n, bhe_n}, 3'b111);
        check({req, " done"}, done, 0);
    endtask

    task automatic txn(input bit wr, input bit io, input bit wd, input logic [19:0] a,
                       input logic [1:0] sg, input logic [15:0] wdat, input int waits);
        int          nparts;
        logic [19:0] ca;
        logic        ebhe;
        logic [7:0]  b;
        logic [15:0] lane;
        logic [15:0] er;
        nparts = (wd && a[0]) ? 2 : 1;
        @(negedge clk);
        check_idle("R1 idle before request");
        req_valid = 1'b1; req_write = wr; req_io = io; req_word = wd;
        req_addr = a; req_seg = sg; req_wdata = wdat;
        @(negedge clk);
        // R2: inputs ignored once accepted
        req_valid = 1'b0; req_write = ~wr; req_io = ~io; req_word = ~wd;
        req_addr = ~a; req_seg = ~sg; req_wdata = ~wdat;
        for (int p = 0; p < nparts; p++) begin
            if (p > 0) @(negedge clk);
            ca   = (p == 0) ? a : a + 20'd1;
            ebhe = (wd && !a[0]) ? 1'b0 : !ca[0];
            b    = (nparts == 2 && p == 1) ? wdat[15:8] : wdat[7:0];
            lane = (wd && !a[0]) ? wdat : {b, b};
            ad_in = pat(ca);
            // T1
            check("R2 ale in T1", ale, 1);
            check("R2 address lines", {ad_oe, ad_out}, {1'b1, ca[15:0]});
            check("R2 upper address", {ast_oe, ast_out}, {1'b1, ca[19:16]});
            check("R7 byte select", {bhe_n, ad_out[0]}, {ebhe, ca[0]});
            check("R9 split address", ad_out[0], (nparts == 2) ? ((p == 0) ? 1 : 0) : a[0]);
            check("R11 mio T1", mio, !io);
            check("R3 R4 dtr T1", {dtr, den, rd_n, wr_n}, {wr, 3'b011});
            for (int s = 0; s < 2 + waits; s++) begin
                @(negedge clk);
                if (s == 1) ready = (waits == 0);
                if (s >= 2) ready = (s == waits + 1);
                check("R2 ale low", ale, 0);
                check("R5 busy in data phase", {busy, done}, 2'b10);
                check("R6 status", {ast_oe, ast_out}, {3'b100, sg});
                check("R7 bhe held", bhe_n, ebhe);
                check("R11 mio", mio, !io);
                if (wr) begin
                    check("R4 write phase", {ad_oe, wr_n, rd_n, den, dtr}, 5'b10111);
                    check("R8 R9 write lanes", ad_out, lane);
                end else begin
                    check("R3 read phase", {ad_oe, rd_n, wr_n, den, dtr}, 5'b00110);
                end
            end
            @(negedge clk);
            ready = 1'b1;
            // T4
            check("R5 T4 reached after waits", {rd_n, wr_n, den, ale}, 4'b1100);
            check("R10 done", done, (p == nparts - 1));
            check("R6 status T4", ast_out, {2'b00, sg});
            if (wr) begin
                check("R4 write held T4", {ad_oe, ad_out}, {1'b1, lane});
                check("R4 dtr T4", dtr, 1);
            end else begin
                check("R3 read T4", {ad_oe, dtr}, 2'b00);
            end
        end
        if (!wr) begin
            if (!wd)
                er = {8'h00, a[0] ? pat(a)[15:8] : pat(a)[7:0]};
            else if (!a[0])
                er = pat(a);
            else
                er = {pat(a + 20'd1)[7:0], pat(a)[15:8]};
            check(wd ? (a[0] ? "R9 split read data" : "R8 word read data") : "R8 byte read data",
                  rdata, er);
        end
        @(negedge clk);
        check_idle("R10 idle after done");
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        logic [19:0] addrs [4];
        addrs[0] = 20'h0A820; addrs[1] = 20'h3C5B1; addrs[2] = 20'hFFFFE; addrs[3] = 20'hFFFFF;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_io = 1'b0; req_word = 1'b0;
        req_addr = '0; req_seg = '0; req_wdata = '0; ready = 1'b1; ad_in = '0;
        repeat (3) @(negedge clk);
        check_idle("R1 reset state");
        check("R1 reset rdata", rdata, 0);
        rst_n = 1'b1;
        for (int wr = 0; wr < 2; wr++)
            for (int io = 0; io < 2; io++)
                for (int wd = 0; wd < 2; wd++)
                    for (int k = 0; k < 4; k++)
                        for (int sg = 0; sg < 4; sg++)
                            txn(wr[0], io[0], wd[0], addrs[k] ^ {14'd0, sg[1:0], 4'd0},
                                sg[1:0], 16'hB400 + 16'(k * 37 + sg * 5 + wr),
                                (k + sg + wd) % 4);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule